// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block sits between a synchronous host and an external asynchronous static RAM of 131072 bytes. The host hands over one read or one write at a time through a valid/ready handshake carrying a 17-bit word address and a byte of write data. The controller turns each request into the pin sequence the memory expects. It drives the address lines, an active-low select, an active-high enable, an active-low write strobe and an active-low output enable. It also drives a bidirectional byte-wide data bus through a tristate.

The memory's analog timing limits are given as picosecond parameters next to the clock period. Each limit is rounded up to whole clock cycles. The controller meets the write strobe width, the write cycle time with its recovery gap, the read access time and the output release time by counting those cycles.

For a read, the controller samples the data bus on the last access cycle and returns the byte to the host as a one-cycle response pulse. Writes complete with no response. While a request is in progress, ready stays low, so any new request waits.

Top module: `sram_async_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle after. A request presented while busy waits until `req_ready` returns.
- R2: Every write holds `mem_wr_n` low for exactly WL = ceil(T_WL_PS/CLK_PS) consecutive cycles, which is 5 at the defaults.
- R3: While `mem_wr_n` is low, `mem_addr` does not change, `mem_sel_n` is low and `mem_en` is high.
- R4: The controller drives `mem_dq` only while `mem_wr_n` is low, and drives the byte from the accepted request. A write strobe never starts until at least ceil(T_OZ_PS/CLK_PS) cycles (3 at the defaults) after `mem_oe_n` has gone high, so the memory's output drivers never overlap it.
- R5: After `mem_wr_n` rises, it stays high for at least REC = max(ceil(T_WREC_PS/CLK_PS), ceil(T_WC_PS/CLK_PS) - WL) cycles before the next fall, which is 2 at the defaults.
- R6: Every read holds `mem_oe_n` low for exactly ceil(T_ACC_PS/CLK_PS) consecutive cycles (7 at the defaults). During that time `mem_wr_n` is high, `mem_sel_n` is low and `mem_en` is high, and the bus is sampled on the last of those cycles.
- R7: `rsp_valid` is high for exactly one cycle per read, in the cycle after the bus is sampled, and `rsp_rdata` holds the sampled byte.
- R8: During reset `req_ready` is high, `rsp_valid` is low, `mem_sel_n` is high, `mem_en` is low, and `mem_wr_n` and `mem_oe_n` are high.
- R9: A read of any address, including 0 and 0x1FFFF, returns the byte most recently written there, or the byte the memory holds if that address was never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | Memory address lines |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_en | output | 1 | Memory enable, active high |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | inout | 8 | Bidirectional data bus |

## Verification
Two events can land in the same cycle. The memory can still be releasing the bus after a read, and the host can already be presenting the next request, which here is a write. The bench provokes this by handing over a write immediately after a read to the same address, with `req_valid` raised while the controller is still busy. The behavioural memory keeps driving the bus for a few cycles after its output enable rises. On every strobe-low cycle, the bench flags any overlap between that drive and the write. It also checks that the read response still carries the old byte, and that a following read returns the new one.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 4000,
  parameter int T_WL_PS   = 20000,
  parameter int T_WREC_PS = 5000,
  parameter int T_WC_PS   = 25000,
  parameter int T_ACC_PS  = 25000,
  parameter int T_OZ_PS   = 9000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_en,
  output logic              mem_wr_n,
  output logic              mem_oe_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int WL_RAW  = (T_WL_PS + CLK_PS - 1) / CLK_PS;
  localparam int WL_CYC  = (WL_RAW < 1) ? 1 : WL_RAW;
  localparam int REC_A   = (T_WREC_PS + CLK_PS - 1) / CLK_PS;
  localparam int REC_B   = (T_WC_PS + CLK_PS - 1) / CLK_PS - WL_CYC;
  localparam int REC_RAW = (REC_A > REC_B) ? REC_A : REC_B;
  localparam int REC_CYC = (REC_RAW < 1) ? 1 : REC_RAW;
  localparam int RD_RAW  = (T_ACC_PS + CLK_PS - 1) / CLK_PS;
  localparam int RD_CYC  = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int OZ_RAW  = (T_OZ_PS + CLK_PS - 1) / CLK_PS;
  localparam int OZ_CYC  = (OZ_RAW < 1) ? 1 : OZ_RAW;
  localparam int MAX_AB  = (WL_CYC > REC_CYC) ? WL_CYC : REC_CYC;
  localparam int MAX_CD  = (RD_CYC > OZ_CYC) ? RD_CYC : OZ_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WLOW, S_WREC, S_RACC, S_RREL
  } state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               cnt_done;
  logic               selected;
  logic               dq_drive;

  assign cnt_done  = (cnt == '0);
  assign selected  = (st == S_WSET) || (st == S_WLOW) || (st == S_WREC) || (st == S_RACC);
  assign dq_drive  = (st == S_WLOW);

  assign req_ready = (st == S_IDLE);
  assign mem_addr  = addr_q;
  assign mem_sel_n = ~selected;
  assign mem_en    = selected;
  assign mem_wr_n  = (st != S_WLOW);
  assign mem_oe_n  = (st != S_RACC);
  assign mem_dq    = dq_drive ? wdata_q : {DATA_W{1'bz}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          if (req_write) begin
            st <= S_WSET;
          end else begin
            st  <= S_RACC;
            cnt <= CNT_W'(RD_CYC - 1);
          end
        end
        S_WSET: begin
          st  <= S_WLOW;
          cnt <= CNT_W'(WL_CYC - 1);
        end
        S_WLOW: if (cnt_done) begin
          st  <= S_WREC;
          cnt <= CNT_W'(REC_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WREC: if (cnt_done) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        S_RACC: if (cnt_done) begin
          rsp_rdata <= mem_dq;
          rsp_valid <= 1'b1;
          st        <= S_RREL;
          cnt       <= CNT_W'(OZ_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_RREL: if (cnt_done) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [15:0] wl_len, hi_len, oe_off_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wl_len     <= '0;
      hi_len     <= 16'hFFFF;
      oe_off_len <= 16'hFFFF;
    end else begin
      wl_len     <= !mem_wr_n ? ((wl_len == 16'hFFFF) ? wl_len : wl_len + 1'b1) : '0;
      hi_len     <=  mem_wr_n ? ((hi_len == 16'hFFFF) ? hi_len : hi_len + 1'b1) : '0;
      oe_off_len <=  mem_oe_n ? ((oe_off_len == 16'hFFFF) ? oe_off_len : oe_off_len + 1'b1) : '0;
    end
  end

  a_r1_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r2_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> (wl_len == 16'(WL_CYC)));

  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n && $past(!mem_wr_n) |-> $stable(mem_addr) && !mem_sel_n && mem_en);

  a_r4_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (oe_off_len >= 16'(OZ_CYC)) && mem_oe_n);

  a_r5_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> (hi_len >= 16'(REC_CYC)));

  a_r6_read_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_wr_n && !mem_sel_n && mem_en);

  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  wire         req_ready, rsp_valid;
  wire  [7:0]  rsp_rdata;
  wire  [16:0] mem_addr;
  wire         mem_sel_n, mem_en, mem_wr_n, mem_oe_n;
  wire  [7:0]  mem_dq;

  always #2 clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_en(mem_en), .mem_wr_n(mem_wr_n),
    .mem_oe_n(mem_oe_n), .mem_dq(mem_dq));

  int n_checks = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] model_mem [logic [16:0]];
  logic [7:0] ref_mem   [logic [16:0]];
  logic [7:0] exp_wq[$];
  logic [7:0] exp_rq[$];

  function automatic logic [7:0] mrd(input logic [16:0] a);
    return model_mem.exists(a) ? model_mem[a] : 8'h00;
  endfunction

  logic        mdrive = 1'b0;
  logic [7:0]  mval = '0;
  assign mem_dq = mdrive ? mval : 8'hzz;

  int          acc_cnt = 0, hold = 0, wl_run = 0, hi_run = 0, oe_run = 0;
  bit          prev_wr_n = 1, prev_oe_n = 1, prev_rsp = 0, seen_rise = 0;
  bit          bad_a = 0, bad_d = 0, bad_c = 0, bad_r = 0;
  logic [16:0] addr_fall = '0;
  logic [7:0]  wd_last = '0, exp_d;

  always @(negedge clk) if (rst_n) begin
    if (!mem_wr_n) begin
      if (prev_wr_n) begin
        if (seen_rise) chk(hi_run >= 2, "R5 recovery", hi_run, 2);
        wl_run = 1; addr_fall = mem_addr; bad_a = 0; bad_d = 0; bad_c = 0;
      end else wl_run++;
      if (mem_addr !== addr_fall || mem_sel_n || !mem_en) bad_a = 1;
      if (mdrive) bad_c = 1;
      exp_d = (exp_wq.size() > 0) ? exp_wq[0] : 8'h00;
      if (mem_dq !== exp_d) bad_d = 1;
      wd_last = mem_dq;
    end else begin
      if (!prev_wr_n) begin
        chk(wl_run == 5, "R2 strobe width", wl_run, 5);
        chk(!bad_a, "R3 addr/select over strobe", bad_a, 0);
        chk(!bad_d && !bad_c, "R4 bus drive during strobe", {bad_d, bad_c}, 0);
        model_mem[addr_fall] = wd_last;
        if (exp_wq.size() > 0) void'(exp_wq.pop_front());
        seen_rise = 1; hi_run = 1;
      end else hi_run++;
    end

    if (!mem_oe_n) begin
      if (prev_oe_n) begin oe_run = 1; bad_r = 0; end else oe_run++;
      if (!mem_wr_n || mem_sel_n || !mem_en) bad_r = 1;
    end else if (!prev_oe_n) begin
      chk(oe_run == 7 && !bad_r, "R6 read window", oe_run, 7);
    end

    if (!mem_sel_n && mem_en && !mem_oe_n && mem_wr_n) begin
      acc_cnt++;
      hold = 2;
      mdrive = 1;
      mval = (acc_cnt >= 7) ? mrd(mem_addr) : ~mrd(mem_addr);
    end else begin
      acc_cnt = 0;
      mdrive = (hold > 0);
      if (hold > 0) hold--;
    end

    if (prev_rsp) chk(!rsp_valid, "R7 single-cycle response", rsp_valid, 0);
    if (rsp_valid) begin
      exp_d = (exp_rq.size() > 0) ? exp_rq.pop_front() : 8'hEE;
      chk(rsp_rdata === exp_d, "R9 read-back data", rsp_rdata, exp_d);
    end

    prev_wr_n = mem_wr_n; prev_oe_n = mem_oe_n; prev_rsp = rsp_valid;
  end

  task automatic issue(input bit w, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    if (!req_ready) chk(!req_ready, "R1 stall while busy", req_ready, 0);
    while (!req_ready) @(negedge clk);
    if (w) begin
      ref_mem[a] = d;
      exp_wq.push_back(d);
    end else begin
      exp_rq.push_back(ref_mem.exists(a) ? ref_mem[a] : 8'h00);
    end
    @(negedge clk);
    chk(!req_ready, "R1 ready drops after accept", req_ready, 0);
    req_valid = 0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready, "R8 ready in reset", req_ready, 1);
    chk(!rsp_valid, "R8 no response in reset", rsp_valid, 0);
    chk(mem_sel_n && !mem_en, "R8 deselected in reset", {mem_sel_n, mem_en}, 2);
    chk(mem_wr_n && mem_oe_n, "R8 strobes idle in reset", {mem_wr_n, mem_oe_n}, 3);
    rst_n = 1;
    issue(1, 17'h00000, 8'h3C);
    issue(1, 17'h1FFFF, 8'hC3);
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    issue(0, 17'h0AAAA, 8'h00);
    issue(1, 17'h12345, 8'h5A);
    issue(0, 17'h12345, 8'h00);
    issue(1, 17'h12345, 8'hA7);
    issue(0, 17'h12345, 8'h00);
    for (int i = 0; i < 8; i++) issue(1, 17'(i * 17'h2A55), 8'(8'h11 * i + 8'h0F));
    for (int i = 7; i >= 0; i--) issue(0, 17'(i * 17'h2A55), 8'h00);
    repeat (20) @(negedge clk);
    chk(exp_rq.size() == 0, "R7 every read answered", exp_rq.size(), 0);
    chk(req_ready, "R1 idle at end", req_ready, 1);
    summary();
  end
endmodule